// File: doc/BRIEF.md
# Triggered Sample Capture Memory

This block is one acquisition channel for test runs. Every clock brings a 10-bit digitised sample, which enters a shift pipeline. When a trigger arrives, the channel does not store the live sample. It stores the one that entered the pipeline a programmed number of cycles earlier, so the stored data lines up with the trigger's delay.

There are two capture modes. In single mode each accepted trigger stores one word. In temporal mode it stores a burst of consecutive delayed samples, up to 32 words long. Words fill a 1024-entry run memory in order, starting at address zero. When the memory is full, the channel stops storing. A run-clear pulse starts a new run.

Between runs the memory is read through an address and a read strobe. The word comes back one cycle later. A word counter reports how many samples the run holds.

Top module: `trig_capture_mem`

## Requirements
- R1: After reset, `word_count` is 0, `busy`, `full` and `overflow` are low, and `rd_data` is 0.
- R2: A trigger accepted at clock edge T stores the sample that was on `sample_in` at edge T-L, where L is `latency`. A latency of 0 is treated as 1. `latency` must stay stable during a run.
- R3: In single mode (`mode_temporal`=0), each accepted trigger stores exactly one word. It goes to the address equal to `word_count` before the trigger, and the count then rises by one. `burst_len` has no effect in this mode.
- R4: In temporal mode (`mode_temporal`=1), an accepted trigger at edge T stores N consecutive delayed samples on edges T to T+N-1. N is `burst_len`, with 0 read as 1 and values above 32 read as 32. `busy` is high for the N-1 cycles after the trigger edge.
- R5: A trigger that arrives while `busy` is high stores nothing and does not lengthen the burst. It sets `overflow`, which stays set until run clear.
- R6: When `word_count` reaches 1024, `full` goes high, any burst in progress ends early, and further triggers are ignored without setting `overflow`.
- R7: A `run_clr` pulse sets `word_count` to 0 and clears `full`, `overflow` and `busy` on the next edge.
- R8: With `rd_en` high at an edge, `rd_data` shows the word stored at `rd_addr` after that edge. While `rd_en` is low, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_clr | input | 1 | Starts a new run: clears the count and the flags |
| mode_temporal | input | 1 | 0 selects single capture, 1 selects burst capture |
| burst_len | input | 6 | Number of words per trigger in temporal mode |
| latency | input | 8 | Trigger latency in cycles (1 to 255) |
| sample_in | input | 10 | Incoming digitised sample |
| trigger | input | 1 | Capture request |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 10 | Read address |
| rd_data | output | 10 | Read word, valid one cycle after the strobe |
| word_count | output | 11 | Number of words stored in this run |
| busy | output | 1 | Burst write in progress |
| full | output | 1 | Run memory full |
| overflow | output | 1 | A trigger was dropped during a burst |

## Verification
The hardest state to reach from the ports is a burst cut short by a memory that is nearly full. The stimulus fills 1022 words with 31 full bursts and 30 single captures. It then fires an 8-word burst, of which only two words may land. Both the final count and those last two addresses are checked. Every sample is a known function of its edge number, so each stored word shows whether the latency and the ordering within the burst were correct.

// File: rtl/trig_capture_mem.sv
module trig_capture_mem #(
  parameter int SAMPLE_W  = 10,
  parameter int MEM_DEPTH = 1024,
  parameter int MAX_BURST = 32,
  parameter int MAX_LAT   = 255
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           run_clr,
  input  logic                           mode_temporal,
  input  logic [$clog2(MAX_BURST+1)-1:0] burst_len,
  input  logic [$clog2(MAX_LAT+1)-1:0]   latency,
  input  logic [SAMPLE_W-1:0]            sample_in,
  input  logic                           trigger,
  input  logic                           rd_en,
  input  logic [$clog2(MEM_DEPTH)-1:0]   rd_addr,
  output logic [SAMPLE_W-1:0]            rd_data,
  output logic [$clog2(MEM_DEPTH):0]     word_count,
  output logic                           busy,
  output logic                           full,
  output logic                           overflow
);
  localparam int AW = $clog2(MEM_DEPTH);
  localparam int BW = $clog2(MAX_BURST+1);
  localparam int LW = $clog2(MAX_LAT+1);

  logic [SAMPLE_W-1:0] pipe [MAX_LAT];
  logic [SAMPLE_W-1:0] mem  [MEM_DEPTH];
  logic [AW:0]         cnt;
  logic [BW-1:0]       remain;
  logic [BW-1:0]       len_eff;
  logic [LW-1:0]       lat_eff;
  logic                start, wr_en, last_slot, ovf_q;

  assign lat_eff   = (latency == '0) ? LW'(1) :
                     (int'(latency) > MAX_LAT) ? LW'(MAX_LAT) : latency;
  assign len_eff   = !mode_temporal ? BW'(1) :
                     (burst_len == '0) ? BW'(1) :
                     (int'(burst_len) > MAX_BURST) ? BW'(MAX_BURST) : burst_len;
  assign full      = (cnt == (AW+1)'(MEM_DEPTH));
  assign busy      = (remain != '0);
  assign start     = trigger && !busy && !full && !run_clr;
  assign wr_en     = start || (busy && !run_clr);
  assign last_slot = (cnt == (AW+1)'(MEM_DEPTH-1));
  assign word_count = cnt;
  assign overflow  = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_LAT; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= sample_in;
      for (int i = 1; i < MAX_LAT; i++) pipe[i] <= pipe[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[cnt[AW-1:0]] <= pipe[lat_eff - LW'(1)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      remain <= '0;
      ovf_q  <= 1'b0;
    end else if (run_clr) begin
      cnt    <= '0;
      remain <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_en) cnt <= cnt + 1'b1;
      if (start) remain <= last_slot ? '0 : len_eff - BW'(1);
      else if (busy) remain <= last_slot ? '0 : remain - BW'(1);
      if (trigger && busy) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(MEM_DEPTH));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !run_clr |=> overflow);

  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && !run_clr |=> $stable(word_count));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trigger && !busy && !full && !mode_temporal && !run_clr
    |=> word_count == (AW+1)'($past(word_count) + 1'b1));

  // R4
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !run_clr |=> word_count == (AW+1)'($past(word_count) + 1'b1));

  // R7
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_clr |=> word_count == '0 && !overflow && !busy);
endmodule

// File: tb/trig_capture_mem_test.sv
module trig_capture_mem_test;
  logic       clk = 0, rst_n = 0, run_clr = 0, mode_temporal = 0, trigger = 0, rd_en = 0;
  logic [5:0] burst_len = 0;
  logic [7:0] latency = 1;
  logic [9:0] sample_in = 0, rd_addr = 0;
  logic [9:0] rd_data;
  logic [10:0] word_count;
  logic busy, full, overflow;

  int checks = 0, failures = 0, k = 0, exp_cnt = 0;
  logic [9:0] exp_mem [1024];
  bit done = 0;

  // {mode, burst_len, latency, expected words}
  localparam logic [20:0] VEC [8] = '{
    {1'b0, 6'd0,  8'd1,   6'd1},
    {1'b0, 6'd0,  8'd5,   6'd1},
    {1'b1, 6'd4,  8'd3,   6'd4},
    {1'b1, 6'd0,  8'd2,   6'd1},
    {1'b1, 6'd40, 8'd7,   6'd32},
    {1'b0, 6'd9,  8'd255, 6'd1},
    {1'b1, 6'd32, 8'd1,   6'd32},
    {1'b0, 6'd0,  8'd0,   6'd1}
  };

  trig_capture_mem uut (.clk(clk), .rst_n(rst_n), .run_clr(run_clr),
    .mode_temporal(mode_temporal), .burst_len(burst_len), .latency(latency),
    .sample_in(sample_in), .trigger(trigger), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .word_count(word_count), .busy(busy), .full(full),
    .overflow(overflow));

  always #4 clk = ~clk;

  function automatic logic [9:0] fval(input int n);
    return 10'((n * 37 + 11) & 1023);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic trg);
    sample_in = fval(k);
    trigger = trg;
    @(posedge clk);
    k++;
    @(negedge clk);
    trigger = 0;
  endtask

  task automatic capture(input logic m, input logic [5:0] len, input logic [7:0] lat, input int n);
    int le, k0;
    le = (lat == 0) ? 1 : int'(lat);
    k0 = k;
    mode_temporal = m; burst_len = len; latency = lat;
    for (int i = 0; i < n; i++) exp_mem[(exp_cnt + i) & 1023] = fval(k0 - le + i);
    exp_cnt += n;
    tick(1);
  endtask

  task automatic read_chk(input int a, input string req);
    rd_en = 1; rd_addr = 10'(a);
    tick(0);
    rd_en = 0;
    chk(rd_data == exp_mem[a], req, int'(rd_data), int'(exp_mem[a]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) tick(0);
    // R1 reset state
    chk(word_count == 0 && !busy && !full && !overflow && rd_data == 0, "R1",
        int'(word_count), 0);
    rst_n = 1;
    repeat (300) tick(0);

    // vector table: R2 R3 R4
    foreach (VEC[v]) begin
      capture(VEC[v][20], VEC[v][19:14], VEC[v][13:6], int'(VEC[v][5:0]));
      repeat (int'(VEC[v][5:0]) + 1) tick(0);
      chk(int'(word_count) == exp_cnt, "R3/R4 count", int'(word_count), exp_cnt);
    end
    for (int a = 0; a < exp_cnt; a++) read_chk(a, "R2 stored sample");

    // R8 hold when strobe low
    rd_addr = 10'd3;
    tick(0);
    chk(rd_data == exp_mem[exp_cnt-1], "R8 hold", int'(rd_data), int'(exp_mem[exp_cnt-1]));

    // R5 trigger during a burst
    latency = 4;
    capture(1'b1, 6'd8, 8'd4, 8);
    chk(busy == 1, "R4 busy", int'(busy), 1);
    tick(0); tick(0);
    tick(1);
    chk(overflow == 1, "R5 overflow", int'(overflow), 1);
    repeat (6) tick(0);
    chk(busy == 0 && int'(word_count) == exp_cnt, "R5 no extra words", int'(word_count), exp_cnt);
    for (int a = exp_cnt - 8; a < exp_cnt; a++) read_chk(a, "R5 burst data");

    // R7 run clear
    run_clr = 1; tick(0); run_clr = 0;
    chk(word_count == 0 && !overflow && !full && !busy, "R7", int'(word_count), 0);
    exp_cnt = 0;

    // R6 fill with truncated final burst
    for (int b = 0; b < 31; b++) begin
      capture(1'b1, 6'd32, 8'd6, 32);
      repeat (31) tick(0);
    end
    for (int s = 0; s < 30; s++) capture(1'b0, 6'd0, 8'd6, 1);
    chk(int'(word_count) == 1022 && !full, "R6 near full", int'(word_count), 1022);
    capture(1'b1, 6'd8, 8'd6, 2);
    repeat (8) tick(0);
    chk(int'(word_count) == 1024 && full && !busy, "R6 full", int'(word_count), 1024);
    tick(1);
    tick(0);
    chk(int'(word_count) == 1024 && !overflow, "R6 ignored trigger", int'(word_count), 1024);
    read_chk(1022, "R6 truncated burst");
    read_chk(1023, "R6 truncated burst");
    read_chk(0, "R6 first word");
    read_chk(500, "R6 mid word");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule